// File: doc/BRIEF.md
# Memory-to-Memory Three-Address Byte Sequencer

This block is the control and datapath of a small 8-bit machine in which every arithmetic operand lives in memory. One byte-wide memory port carries everything. The sequencer reads an opcode byte. It then reads up to three 16-bit absolute addresses, one byte per access. It reads the source operands, spends one cycle computing, and stores the result at the destination address. There is no register file. The only storage is the program counter and the holding registers that the instruction in flight needs.

A memory access starts when `mem_req` is raised and finishes on the rising edge where `mem_req` and `mem_ready` are both high. A memory that raises `mem_ready` in the second cycle of a request gives two cycles per access. With that memory a three-operand instruction takes 7 fetch accesses, 2 operand reads and 1 result write, plus one execute cycle: 21 cycles in all.

The controller walks these named states:
- `ST_OPC`: reads the opcode at the PC. A defined opcode goes to `ST_DST_LO`. An undefined opcode goes to `ST_HALT`.
- `ST_DST_LO` → `ST_DST_HI` → `ST_SA_LO` → `ST_SA_HI`: fetch the destination address and then the first-source address.
- `ST_SA_HI`: goes to `ST_SB_LO` for two-source opcodes and to `ST_RD_A` for the copy opcode.
- `ST_SB_LO` → `ST_SB_HI` → `ST_RD_A`: fetch the second-source address.
- `ST_RD_A`: reads the first operand, then goes to `ST_RD_B` for two-source opcodes and to `ST_EXEC` for the copy opcode.
- `ST_RD_B` → `ST_EXEC`: reads the second operand.
- `ST_EXEC` → `ST_WR_D`: one cycle of computation with no memory access.
- `ST_WR_D` → `ST_OPC`: writes the result.
- `ST_HALT`: loops on itself until reset.

Each memory state waits in place until its access completes.

Top module: `mm3_seq`

## Requirements
- R1: While reset is asserted and when it is released, the block requests a read (`mem_we`=0) of address 0x0000 with `illegal` low. A reset clears a halt.
- R2: Instruction bytes are read from consecutive addresses starting at the PC, which advances by one per fetched byte. The order is opcode, destination low, destination high, source-A low, source-A high, source-B low, source-B high. Each address is stored low byte first.
- R3: Opcodes 0x01 ADD, 0x02 SUB (A minus B), 0x03 AND, 0x04 OR and 0x05 XOR write the 8-bit result, modulo 256, of operand A and operand B to the destination address.
- R4: Opcode 0x06 (copy) is 5 bytes long. It has no source-B field and does no source-B read. It writes operand A to the destination, and the next opcode is read at the PC plus 5.
- R5: While a request waits for `mem_ready`, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady. An access completes only on an edge where `mem_req` and `mem_ready` are both high.
- R6: A three-operand instruction makes exactly 10 accesses in this order: 7 fetches, read A, read B, write. With a two-cycle memory its write completes on the 21st edge after reset release. A copy makes 7 accesses and writes on the 15st edge. Longer memory latency stretches each access and nothing else.
- R7: Any opcode outside 0x01 to 0x06 raises `illegal` after the opcode access. No further requests and no write follow until reset.
- R8: `mem_we` is high only together with `mem_req`. Each instruction writes exactly once, after its operand reads.
- R9: Both operands are read before the write, so a destination that aliases a source yields the result computed from the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Access completes on this edge when `mem_req` is high |
| illegal | output | 1 | Undefined opcode seen; the sequencer is halted |

## Verification
The bound checker watches, on every cycle, that requests are held steady while they wait and that a write request is never issued without `mem_req`. It also watches that a halt is sticky and silent, that no two writes come back to back, and that the first request after reset reads address zero. The bench's scenarios are the only place where the rest can be seen. That covers the arithmetic result of each opcode, the exact order and addresses of the ten (or seven) accesses, and the edge on which the write lands at each memory latency. It also covers the PC hand-off between chained instructions and the handling of aliased operands.

// File: rtl/mm3_pkg.sv
package mm3_pkg;

    typedef enum logic [3:0] {
        ST_OPC,
        ST_DST_LO,
        ST_DST_HI,
        ST_SA_LO,
        ST_SA_HI,
        ST_SB_LO,
        ST_SB_HI,
        ST_RD_A,
        ST_RD_B,
        ST_EXEC,
        ST_WR_D,
        ST_HALT
    } seq_state_t;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_PASS
    } alu_op_t;

    typedef enum logic [1:0] {
        SEL_PC,
        SEL_DST,
        SEL_SA,
        SEL_SB
    } addr_sel_t;

    localparam int NUM_FIELDS = 3;

    localparam logic [7:0] OPC_ADD = 8'h01;
    localparam logic [7:0] OPC_SUB = 8'h02;
    localparam logic [7:0] OPC_AND = 8'h03;
    localparam logic [7:0] OPC_OR  = 8'h04;
    localparam logic [7:0] OPC_XOR = 8'h05;
    localparam logic [7:0] OPC_MOV = 8'h06;

endpackage

// File: rtl/mm3_decode.sv
module mm3_decode
    import mm3_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opc,
    output logic          valid,
    output logic          two_src,
    output alu_op_t       alu_op
);

    always_comb begin
        valid   = 1'b1;
        two_src = 1'b1;
        alu_op  = ALU_ADD;
        unique case (opc)
            DW'(OPC_ADD): alu_op = ALU_ADD;
            DW'(OPC_SUB): alu_op = ALU_SUB;
            DW'(OPC_AND): alu_op = ALU_AND;
            DW'(OPC_OR):  alu_op = ALU_OR;
            DW'(OPC_XOR): alu_op = ALU_XOR;
            DW'(OPC_MOV): begin
                alu_op  = ALU_PASS;
                two_src = 1'b0;
            end
            default: begin
                valid   = 1'b0;
                two_src = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mm3_alu.sv
module mm3_alu
    import mm3_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_t       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_PASS: y = a;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/mm3_ctrl.sv
module mm3_ctrl
    import mm3_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mem_ready,
    input  logic       opc_valid,
    input  logic       two_src,
    output seq_state_t state,
    output logic       req,
    output logic       we,
    output addr_sel_t  addr_sel,
    output logic       in_opc,
    output logic       halted
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       done;

    assign state = state_q;
    assign done  = req & mem_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPC;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPC:    if (done) state_d = opc_valid ? ST_DST_LO : ST_HALT;
            ST_DST_LO: if (done) state_d = ST_DST_HI;
            ST_DST_HI: if (done) state_d = ST_SA_LO;
            ST_SA_LO:  if (done) state_d = ST_SA_HI;
            ST_SA_HI:  if (done) state_d = two_src ? ST_SB_LO : ST_RD_A;
            ST_SB_LO:  if (done) state_d = ST_SB_HI;
            ST_SB_HI:  if (done) state_d = ST_RD_A;
            ST_RD_A:   if (done) state_d = two_src ? ST_RD_B : ST_EXEC;
            ST_RD_B:   if (done) state_d = ST_EXEC;
            ST_EXEC:   state_d = ST_WR_D;
            ST_WR_D:   if (done) state_d = ST_OPC;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_HALT;
        endcase
    end

    // outputs per state
    always_comb begin
        req      = 1'b1;
        we       = 1'b0;
        addr_sel = SEL_PC;
        in_opc   = 1'b0;
        halted   = 1'b0;
        unique case (state_q)
            ST_OPC:    in_opc = 1'b1;
            ST_DST_LO,
            ST_DST_HI,
            ST_SA_LO,
            ST_SA_HI,
            ST_SB_LO,
            ST_SB_HI:  addr_sel = SEL_PC;
            ST_RD_A:   addr_sel = SEL_SA;
            ST_RD_B:   addr_sel = SEL_SB;
            ST_EXEC:   req = 1'b0;
            ST_WR_D: begin
                addr_sel = SEL_DST;
                we       = 1'b1;
            end
            ST_HALT: begin
                req    = 1'b0;
                halted = 1'b1;
            end
            default: begin
                req    = 1'b0;
                halted = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mm3_datapath.sv
module mm3_datapath
    import mm3_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state,
    input  logic          done,
    input  addr_sel_t     addr_sel,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] alu_y,
    output logic [DW-1:0] opc_q,
    output logic [DW-1:0] opa_q,
    output logic [DW-1:0] opb_q,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] fld_q [NUM_FIELDS];
    logic [DW-1:0] res_q;
    logic          fetching;

    assign fetching = (state == ST_OPC)    || (state == ST_DST_LO) ||
                      (state == ST_DST_HI) || (state == ST_SA_LO)  ||
                      (state == ST_SA_HI)  || (state == ST_SB_LO)  ||
                      (state == ST_SB_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (done && fetching) begin
            pc_q <= pc_q + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q <= '0;
            opa_q <= '0;
            opb_q <= '0;
            res_q <= '0;
        end else begin
            if (done && state == ST_OPC)  opc_q <= rdata;
            if (done && state == ST_RD_A) opa_q <= rdata;
            if (done && state == ST_RD_B) opb_q <= rdata;
            if (state == ST_EXEC)         res_q <= alu_y;
        end
    end

    // one low/high byte pair per address field
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
        localparam seq_state_t LO_ST = (f == 0) ? ST_DST_LO :
                                       (f == 1) ? ST_SA_LO : ST_SB_LO;
        localparam seq_state_t HI_ST = (f == 0) ? ST_DST_HI :
                                       (f == 1) ? ST_SA_HI : ST_SB_HI;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fld_q[f] <= '0;
            end else if (done && state == LO_ST) begin
                fld_q[f][DW-1:0] <= rdata;
            end else if (done && state == HI_ST) begin
                fld_q[f][AW-1:DW] <= rdata;
            end
        end
    end

    always_comb begin
        unique case (addr_sel)
            SEL_PC:  addr = pc_q;
            SEL_DST: addr = fld_q[0];
            SEL_SA:  addr = fld_q[1];
            SEL_SB:  addr = fld_q[2];
            default: addr = pc_q;
        endcase
    end

    assign wdata = res_q;

endmodule

// File: rtl/mm3_seq.sv
module mm3_seq
    import mm3_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          illegal
);

    seq_state_t    state;
    addr_sel_t     addr_sel;
    alu_op_t       alu_op;
    logic          in_opc;
    logic          opc_valid;
    logic          two_src;
    logic [DW-1:0] opc_q;
    logic [DW-1:0] opa_q;
    logic [DW-1:0] opb_q;
    logic [DW-1:0] alu_y;
    logic [DW-1:0] dec_in;

    // the live byte is decoded in the opcode state, the held one afterwards
    assign dec_in = in_opc ? mem_rdata : opc_q;

    mm3_decode #(.DW(DW)) u_dec (
        .opc     (dec_in),
        .valid   (opc_valid),
        .two_src (two_src),
        .alu_op  (alu_op)
    );

    mm3_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_ready (mem_ready),
        .opc_valid (opc_valid),
        .two_src   (two_src),
        .state     (state),
        .req       (mem_req),
        .we        (mem_we),
        .addr_sel  (addr_sel),
        .in_opc    (in_opc),
        .halted    (illegal)
    );

    mm3_alu #(.DW(DW)) u_alu (
        .op (alu_op),
        .a  (opa_q),
        .b  (opb_q),
        .y  (alu_y)
    );

    mm3_datapath #(.DW(DW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .done     (mem_req & mem_ready),
        .addr_sel (addr_sel),
        .rdata    (mem_rdata),
        .alu_y    (alu_y),
        .opc_q    (opc_q),
        .opa_q    (opa_q),
        .opb_q    (opb_q),
        .addr     (mem_addr),
        .wdata    (mem_wdata)
    );

endmodule

// File: rtl/mm3_seq_chk.sv
module mm3_seq_chk #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready,
    input logic          illegal
);

    logic seen_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_req <= 1'b0;
        else if (mem_req) seen_req <= 1'b1;
    end

    assert_first_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_req && mem_req) |-> (mem_addr == '0 && !mem_we));

    assert_hold_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_hold_wdata_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ready) |=> $stable(mem_wdata));

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_req);

    assert_we_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> !mem_we);

endmodule

bind mm3_seq mm3_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .illegal   (illegal)
);

// File: tb/sim_mm3_seq.sv
module sim_mm3_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, mem_ready, illegal;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    mm3_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .illegal   (illegal)
    );

    // memory model with selectable latency
    logic [7:0]  mem [0:1023];
    logic [15:0] log_addr [0:63];
    logic        log_we [0:63];
    int          lat = 1;
    int          wcnt, acc, wr, cyc, wcyc;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            wcnt <= 0; acc <= 0; wr <= 0; cyc <= 0; wcyc <= 0;
        end else begin
            cyc <= cyc + 1;
            if (mem_req && mem_ready) begin
                mem_ready <= 1'b0;
                log_addr[acc[5:0]] <= mem_addr;
                log_we[acc[5:0]]   <= mem_we;
                acc <= acc + 1;
                if (mem_we) begin
                    mem[mem_addr[9:0]] <= mem_wdata;
                    wr   <= wr + 1;
                    wcyc <= cyc + 1;
                end
            end else if (mem_req) begin
                if (wcnt >= lat - 1) begin
                    mem_ready <= 1'b1;
                    wcnt <= 0;
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    endtask

    task automatic put_addr(input int at, input logic [15:0] a);
        mem[at]     = a[7:0];
        mem[at + 1] = a[15:8];
    endtask

    task automatic go(input int cycles);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(posedge clk);
        #1;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] model(input logic [7:0] op, input logic [7:0] a,
                                         input logic [7:0] b);
        case (op)
            8'h01: return a + b;
            8'h02: return a - b;
            8'h03: return a & b;
            8'h04: return a | b;
            8'h05: return a ^ b;
            default: return a;
        endcase
    endfunction

    localparam logic [15:0] DST = 16'h0123;
    localparam logic [15:0] SA  = 16'h0245;
    localparam logic [15:0] SB  = 16'h0367;

    // opcode, operand A, operand B
    localparam logic [23:0] VEC [8] = '{
        {8'h01, 8'h3C, 8'h55},
        {8'h01, 8'hF0, 8'h20},
        {8'h02, 8'h10, 8'h20},
        {8'h02, 8'h80, 8'h01},
        {8'h03, 8'hCA, 8'h0F},
        {8'h04, 8'hA0, 8'h05},
        {8'h05, 8'hFF, 8'h5A},
        {8'h06, 8'h77, 8'h99}
    };

    // run a single instruction at address 0 and check its traffic
    task automatic run_one(input logic [7:0] op, input logic [7:0] a,
                           input logic [7:0] b, input int latency, input int exp_cyc);
        bit three;
        int n;
        bit seq_ok;
        logic [15:0] exp_log [0:10];
        three = (op != 8'h06);
        hold_reset();
        lat = latency;
        clear_mem();
        mem[0] = op;
        put_addr(1, DST);
        put_addr(3, SA);
        if (three) put_addr(5, SB);
        mem[SA[9:0]] = a;
        mem[SB[9:0]] = b;
        go(12 * (latency + 1) + 6);
        check(three ? "R3 result" : "R4 copy result", mem[DST[9:0]], model(op, a, b));
        check("R8 one write", wr, 1);
        check("R6 write edge", wcyc, exp_cyc);
        n = three ? 7 : 5;
        for (int i = 0; i < n; i++) exp_log[i] = 16'(i);
        exp_log[n] = SA;
        if (three) begin
            exp_log[n + 1] = SB;
            n = n + 1;
        end
        exp_log[n + 1] = DST;
        exp_log[n + 2] = three ? 16'h0007 : 16'h0005;
        seq_ok = 1;
        for (int i = 0; i <= n + 2; i++) begin
            if (log_addr[i] != exp_log[i]) seq_ok = 0;
            if (log_we[i] != (i == n + 1)) seq_ok = 0;
        end
        check("R2 R6 access order and next PC", int'(seq_ok), 1);
        check("R6 access count", acc, n + 3);
    endtask

    initial begin
        clear_mem();
        repeat (2) @(negedge clk);
        // reset state
        check("R1 reset addr", mem_addr, 0);
        check("R1 reset read", mem_we, 0);
        check("R1 reset illegal", illegal, 0);

        // table of vectors, two-cycle memory
        foreach (VEC[i]) begin
            run_one(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1,
                    (VEC[i][23:16] == 8'h06) ? 15 : 21);
        end

        // R5 longer latency stretches only the accesses
        run_one(8'h02, 8'h09, 8'h0C, 3, 41);
        run_one(8'h06, 8'h3A, 8'h00, 2, 22);

        // R9 destination aliases both sources
        hold_reset();
        lat = 1;
        clear_mem();
        mem[0] = 8'h01;
        put_addr(1, 16'h0200);
        put_addr(3, 16'h0200);
        put_addr(5, 16'h0200);
        mem[10'h200] = 8'h21;
        go(40);
        check("R9 aliased add", mem[10'h200], 8'h42);

        // R4 chain: copy then subtract, second opcode at PC 5
        hold_reset();
        clear_mem();
        mem[0] = 8'h06;
        put_addr(1, 16'h0300);
        put_addr(3, SA);
        mem[5] = 8'h02;
        put_addr(6, DST);
        put_addr(8, 16'h0300);
        put_addr(10, SB);
        mem[SA[9:0]] = 8'h50;
        mem[SB[9:0]] = 8'h13;
        go(60);
        check("R4 chained copy", mem[10'h300], 8'h50);
        check("R4 next opcode at PC+5", log_addr[7], 16'h0005);
        check("R3 chained sub", mem[DST[9:0]], 8'h3D);
        check("R8 two writes", wr, 2);

        // R7 undefined opcodes halt silently
        foreach (VEC[k]) begin
            if (k < 3) begin
                logic [7:0] bad;
                bad = (k == 0) ? 8'h00 : (k == 1) ? 8'h07 : 8'hFF;
                hold_reset();
                clear_mem();
                mem[0] = bad;
                put_addr(1, DST);
                put_addr(3, SA);
                put_addr(5, SB);
                mem[SA[9:0]] = 8'h11;
                go(40);
                check("R7 illegal flag", illegal, 1);
                check("R7 single access", acc, 1);
                check("R7 no write", wr, 0);
                check("R7 no request", mem_req, 0);
                check("R7 destination untouched", mem[DST[9:0]], 0);
            end
        end

        // R1 reset clears the halt
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 halt cleared", illegal, 0);
        check("R1 read at zero", mem_addr, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule